// File: doc/BRIEF.md
# Shared Interrupt and Port Register Unit

This block holds the register section that both channels of a dual serial controller share. It packs the transmitter-ready and receiver-ready levels of each channel into a status byte, four bits per channel. It ANDs that byte with a software-written enable mask and drives a single active-low interrupt request line. A host processor writes a mask of enabled sources and then polls or services the line. The line is registered, so an interrupt controller that detects falling edges sees one clean edge.

The block also owns a general-purpose output register. The host changes this register through two write addresses: one sets the bits written as 1, and the other clears the bits written as 1. A read-modify-write sequence is never needed. An output configuration register can route a channel's ready flag to a low-numbered pin in place of the register bit. The raw input pins pass through a two-flop synchronizer, and the host reads them back at two addresses.

Top module: `gpo_irq_unit`

## Requirements
- R1: After a synchronous reset, the enable mask, the output register and the output configuration are all zero. Every output pin is high and irq_n is high.
- R2: A read at address 0x5 returns the live status byte. For channel n, bit 4n is the transmitter-ready level and bit 4n+1 is the receiver-ready level. Bits 4n+2 and 4n+3, and all bits above the last channel, read as 0.
- R3: A write to address 0x5 loads the enable mask. irq_n is low one clock after (status AND mask) is non-zero, and high one clock after it is zero.
- R4: A write to address 0xE sets every output-register bit whose data bit is 1. All other bits keep their value.
- R5: A write to address 0xF clears every output-register bit whose data bit is 1. All other bits keep their value.
- R6: Each output pin drives the complement of its output-register bit while its configuration bit is 0.
- R7: A write to address 0xD loads the output configuration. When configuration bit k is 1 for k below 2*NCH, pin k carries a ready flag inverted: pin 2n carries the transmitter-ready flag of channel n and pin 2n+1 its receiver-ready flag. Configuration bits at or above 2*NCH have no effect on the pins.
- R8: Reads at addresses 0xD and 0x4 return the synchronized input pin levels in the low NIN bits, with the upper bits 0. A pin change becomes visible two clock edges after it is applied, not after one.
- R9: Writes to address 0x4 or to any unmapped address leave the mask, the output register and the configuration unchanged. Reads at unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Register address for reads and writes |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| ch_tx_ready | input | NCH | Transmitter-ready level per channel |
| ch_rx_ready | input | NCH | Receiver-ready level per channel |
| in_pins | input | NIN | Raw input pins (active low by convention) |
| irq_n | output | 1 | Active-low interrupt request |
| out_pins_n | output | NOUT | Output pins, driven inverted |

## Verification
The bench builds the block with its defaults: two channels, eight output pins and six input pins. With two channels, both 4-bit status groups are filled, and the bench can check that the unused bits 2, 3, 6 and 7 read as zero and never raise an interrupt through the mask. Eight pins against four routable flags puts pins 4 to 7 in reach, where configuration bits must have no effect. Six inputs leave the top two read bits available to check the zero padding.

// File: rtl/gpo_irq_pkg.sv
package gpo_irq_pkg;

    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int SRC_PER_CH = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_PIN_LVL = 4'h4,
        ADDR_INTR    = 4'h5,
        ADDR_PIN_CFG = 4'hD,
        ADDR_OUT_SET = 4'hE,
        ADDR_OUT_CLR = 4'hF
    } reg_addr_e;

    typedef struct packed {
        logic mask_we;
        logic cfg_we;
        logic set_we;
        logic clr_we;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] addr);
        wr_strobe_t s;
        s         = '0;
        s.mask_we = we && (addr == ADDR_INTR);
        s.cfg_we  = we && (addr == ADDR_PIN_CFG);
        s.set_we  = we && (addr == ADDR_OUT_SET);
        s.clr_we  = we && (addr == ADDR_OUT_CLR);
        return s;
    endfunction

endpackage

// File: rtl/gpo_irq_mask.sv
module gpo_irq_mask
    import gpo_irq_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NCH-1:0]    tx_rdy,
    input  logic [NCH-1:0]    rx_rdy,
    output logic [DATA_W-1:0] status,
    output logic              irq_n
);
    localparam int SW = SRC_PER_CH * NCH;

    logic [SW-1:0] mask_q;
    logic          irq_q;

    always_comb begin
        status = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            status[SRC_PER_CH*ch]     = tx_rdy[ch];
            status[SRC_PER_CH*ch + 1] = rx_rdy[ch];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b1;
        end else begin
            if (mask_we) mask_q <= wdata[SW-1:0];
            irq_q <= ~|(status[SW-1:0] & mask_q);
        end
    end

    assign irq_n = irq_q;

    // R3: the mask only moves on its own write strobe
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));

    // R3: an all-zero mask keeps the request line released
    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> irq_n);

    // R3: a new mask value is exactly the written data
    assert_mask_load_R3: assert property (@(posedge clk) disable iff (rst)
        mask_we |=> (mask_q == $past(wdata[SW-1:0])));

endmodule

// File: rtl/gpo_out_port.sv
module gpo_out_port
    import gpo_irq_pkg::*;
#(
    parameter int NOUT = 8,
    parameter int NALT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NALT-1:0]   alt_src,
    output logic [NOUT-1:0]   pins_n
);
    logic [NOUT-1:0] out_q;
    logic [NALT-1:0] cfg_q;
    logic [NOUT-1:0] drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            cfg_q <= '0;
        end else begin
            if (set_we) out_q <= out_q | wdata[NOUT-1:0];
            else if (clr_we) out_q <= out_q & ~wdata[NOUT-1:0];
            if (cfg_we) cfg_q <= wdata[NALT-1:0];
        end
    end

    for (genvar k = 0; k < NOUT; k++) begin : g_pin
        if (k < NALT) begin : g_alt
            assign drive[k] = cfg_q[k] ? alt_src[k] : out_q[k];
        end else begin : g_reg
            assign drive[k] = out_q[k];
        end
    end

    assign pins_n = ~drive;

    // R4: set-bits write leaves every written 1 set
    assert_set_bits_R4: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((out_q & $past(wdata[NOUT-1:0])) == $past(wdata[NOUT-1:0])));

    // R5: clear-bits write leaves every written 1 cleared
    assert_clr_bits_R5: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((out_q & $past(wdata[NOUT-1:0])) == '0));

    // R9: without a set or clear strobe the register holds
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(out_q));

    // R9: configuration holds without its strobe
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/gpo_in_sync.sv
module gpo_in_sync #(
    parameter int NIN = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NIN-1:0] raw,
    output logic [NIN-1:0] synced
);
    logic [NIN-1:0] stage1_q;
    logic [NIN-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw;
            stage2_q <= stage1_q;
        end
    end

    assign synced = stage2_q;

    // R8: second stage trails the first by exactly one edge
    assert_sync_chain_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stage2_q == $past(stage1_q)));

endmodule

// File: rtl/gpo_irq_unit.sv
module gpo_irq_unit
    import gpo_irq_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int NOUT = 8,
    parameter int NIN  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [NCH-1:0]    ch_tx_ready,
    input  logic [NCH-1:0]    ch_rx_ready,
    input  logic [NIN-1:0]    in_pins,
    output logic              irq_n,
    output logic [NOUT-1:0]   out_pins_n
);
    localparam int NFLAG = 2 * NCH;
    localparam int NALT  = (NFLAG < NOUT) ? NFLAG : NOUT;

    wr_strobe_t        wstb;
    logic [DATA_W-1:0] status;
    logic [NIN-1:0]    pin_lvl;
    logic [NFLAG-1:0]  flags;

    assign wstb = decode_write(host_we, host_addr);

    for (genvar n = 0; n < NCH; n++) begin : g_flag
        assign flags[2*n]     = ch_tx_ready[n];
        assign flags[2*n + 1] = ch_rx_ready[n];
    end

    gpo_irq_mask #(.NCH(NCH)) u_mask (
        .clk     (clk),
        .rst     (rst),
        .mask_we (wstb.mask_we),
        .wdata   (host_wdata),
        .tx_rdy  (ch_tx_ready),
        .rx_rdy  (ch_rx_ready),
        .status  (status),
        .irq_n   (irq_n)
    );

    gpo_out_port #(.NOUT(NOUT), .NALT(NALT)) u_out (
        .clk     (clk),
        .rst     (rst),
        .set_we  (wstb.set_we),
        .clr_we  (wstb.clr_we),
        .cfg_we  (wstb.cfg_we),
        .wdata   (host_wdata),
        .alt_src (flags[NALT-1:0]),
        .pins_n  (out_pins_n)
    );

    gpo_in_sync #(.NIN(NIN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (in_pins),
        .synced (pin_lvl)
    );

    always_comb begin
        case (host_addr)
            ADDR_INTR:    host_rdata = status;
            ADDR_PIN_LVL,
            ADDR_PIN_CFG: host_rdata = DATA_W'(pin_lvl);
            default:      host_rdata = '0;
        endcase
    end

    // R1: line released in the cycle after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> irq_n);

    // R9: unmapped reads are zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (host_addr != ADDR_INTR && host_addr != ADDR_PIN_LVL && host_addr != ADDR_PIN_CFG)
            |-> (host_rdata == '0));

endmodule

// File: tb/gpo_irq_unit_tb.sv
module gpo_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_we;
    logic [3:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic [1:0] ch_tx_ready;
    logic [1:0] ch_rx_ready;
    logic [5:0] in_pins;
    logic       irq_n;
    logic [7:0] out_pins_n;

    always #4 clk = ~clk;

    gpo_irq_unit #(.NCH(2), .NOUT(8), .NIN(6)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ch_tx_ready(ch_tx_ready), .ch_rx_ready(ch_rx_ready),
        .in_pins(in_pins), .irq_n(irq_n), .out_pins_n(out_pins_n)
    );

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // {tx[1:0], rx[1:0], mask[7:0], expected status[7:0], expected irq_n}
    localparam logic [20:0] VEC [10] = '{
        {2'b00, 2'b00, 8'hFF, 8'h00, 1'b1},
        {2'b01, 2'b00, 8'h01, 8'h01, 1'b0},
        {2'b01, 2'b00, 8'h02, 8'h01, 1'b1},
        {2'b00, 2'b01, 8'h02, 8'h02, 1'b0},
        {2'b10, 2'b00, 8'h10, 8'h10, 1'b0},
        {2'b00, 2'b10, 8'h10, 8'h20, 1'b1},
        {2'b00, 2'b10, 8'h20, 8'h20, 1'b0},
        {2'b11, 2'b11, 8'hCC, 8'h33, 1'b1},
        {2'b11, 2'b11, 8'h00, 8'h33, 1'b1},
        {2'b10, 2'b01, 8'h12, 8'h12, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        rst = 1'b1; host_we = 1'b0; host_addr = 4'h0; host_wdata = 8'h00;
        ch_tx_ready = 2'b11; ch_rx_ready = 2'b11; in_pins = 6'h15;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state with all sources active
        check("R1 pins", out_pins_n, 8'hFF);
        check("R1 irq", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        check("R1 irq later", {7'b0, irq_n}, 8'h01);

        // R2 R3 vector table
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ch_tx_ready = VEC[i][20:19];
            ch_rx_ready = VEC[i][18:17];
            wr(4'h5, VEC[i][16:9]);
            @(negedge clk);
            rd(4'h5, rv);
            check("R2 status", rv, VEC[i][8:1]);
            check("R3 irq", {7'b0, irq_n}, {7'b0, VEC[i][0]});
        end

        // R3: line follows sources, mask 0x12 active with tx1/rx0
        ch_tx_ready = 2'b00; ch_rx_ready = 2'b00;
        @(negedge clk);
        check("R3 release", {7'b0, irq_n}, 8'h01);
        ch_rx_ready = 2'b01;
        @(negedge clk);
        check("R3 reassert", {7'b0, irq_n}, 8'h00);

        // R4 R5 R6 output register
        wr(4'hE, 8'h05);
        check("R4 R6 set", out_pins_n, 8'hFA);
        wr(4'hE, 8'h30);
        check("R4 set keeps", out_pins_n, 8'hCA);
        wr(4'hF, 8'h11);
        check("R5 clear", out_pins_n, 8'hDB);
        wr(4'hF, 8'h00);
        check("R5 clear none", out_pins_n, 8'hDB);

        // R9 ignored writes: pins and mask unchanged
        wr(4'h4, 8'hFF);
        wr(4'h7, 8'hFF);
        wr(4'h0, 8'h00);
        @(negedge clk);
        check("R9 pins", out_pins_n, 8'hDB);
        check("R9 mask kept", {7'b0, irq_n}, 8'h00);
        rd(4'h0, rv);
        check("R9 unmapped read", rv, 8'h00);
        rd(4'hE, rv);
        check("R9 set addr read", rv, 8'h00);

        // R7 configuration routing
        ch_tx_ready = 2'b01; ch_rx_ready = 2'b10;
        wr(4'hD, 8'h0F);
        check("R7 routed", out_pins_n, 8'hD6);
        ch_tx_ready = 2'b10; ch_rx_ready = 2'b01;
        #1;
        check("R7 live", out_pins_n, 8'hD9);
        wr(4'hD, 8'hF0);
        check("R7 upper no effect", out_pins_n, 8'hDB);
        wr(4'hD, 8'h00);
        check("R6 plain", out_pins_n, 8'hDB);

        // R8 input synchronizer
        rd(4'hD, rv);
        check("R8 level", rv, 8'h15);
        in_pins = 6'h2A;
        @(negedge clk);
        rd(4'h4, rv);
        check("R8 one edge", rv, 8'h15);
        @(negedge clk);
        rd(4'h4, rv);
        check("R8 two edges", rv, 8'h2A);
        rd(4'hD, rv);
        check("R8 port read", rv, 8'h2A);

        // R1 reset clears mask and outputs
        wr(4'hE, 8'hFF);
        wr(4'h5, 8'hFF);
        ch_tx_ready = 2'b11;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 pins after reset", out_pins_n, 8'hFF);
        check("R1 mask after reset", {7'b0, irq_n}, 8'h01);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule